// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a circular table of transmit descriptors held in an on-chip store that the host fills through a write port. Each entry carries an ownership flag, start and end-of-frame markers, a per-frame checksum-append request, a completion-notify flag, a buffer address and a byte count. The walker takes only entries that it owns. It chains consecutive entries into a frame and passes each buffer to a downstream data mover as a request carrying the address, the count, first and last flags and a checksum-append decision. It waits for that mover's done pulse before it moves on.

When a buffer is done, the walker hands the entry back to the host by clearing its ownership flag and advances to the next entry. If notification policy allows, it also raises a sticky transmit interrupt. Owned entries that arrive without a start marker while no frame is open are stepped over. A host-owned entry found part way through a frame is reported as an underflow, and the frame is dropped. The checksum decision comes from three inputs: an auto-pad control, a global checksum-disable control and the per-descriptor request. It is taken once per frame.

Top module: `txring_walker`

## Requirements
- R1: After reset no request is valid, the interrupt and underflow outputs are 0, every entry reads back host-owned (ownership bit 0) and the walker points at entry 0.
- R2: An entry whose ownership bit is 0 is never issued as a request; with no frame open the walker waits on it.
- R3: With no frame open, an owned entry whose start marker is 0 is stepped over without a request, and its ownership and marker bits are left as written.
- R4: A request presents the entry's address and count, first=1 only for the buffer that opens a frame, and last equal to the entry's end marker; these hold steady until the done pulse.
- R5: On done, the served entry's ownership bit reads 0 from the next cycle and the walker moves to the next index, wrapping from RING_DEPTH-1 to 0.
- R6: The checksum decision is (NOT global-disable) when auto-pad is 1, else (add-request OR NOT global-disable); it is taken from the first buffer of the frame and reported unchanged on every buffer of that frame.
- R7: With notify-enable at 1, a done on an entry raises the interrupt only if that entry has both the end marker and the notify flag set.
- R8: With notify-enable at 0, the notify flag is ignored and every done on an end-marked entry raises the interrupt.
- R9: The interrupt stays at 1 until a clear pulse; a raise and a clear in the same cycle leave it at 1.
- R10: A host-owned entry met while a frame is open produces a one-cycle underflow pulse, closes the frame and makes the walker look for a start marker again from that same entry.
- R11: Returning an entry to the host changes only its ownership bit; its start, end, add-request and notify bits read back unchanged.
- R12: While the run control is 0, no new request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_run | input | 1 | Allows the walker to take new entries |
| cfg_autopad | input | 1 | Auto-pad mode; overrides the add-request bit |
| cfg_fcs_off | input | 1 | Global checksum-append disable |
| cfg_lti_en | input | 1 | Enables per-entry notify filtering |
| hw_en | input | 1 | Host descriptor write strobe |
| hw_idx | input | IDX_W | Entry index written |
| hw_own | input | 1 | Ownership bit (1 = walker owns) |
| hw_sop | input | 1 | Start-of-frame marker |
| hw_eop | input | 1 | End-of-frame marker |
| hw_add_fcs | input | 1 | Per-frame checksum-append request |
| hw_lti | input | 1 | Notify flag for the frame's last entry |
| hw_addr | input | ADDR_W | Buffer address |
| hw_cnt | input | CNT_W | Buffer byte count |
| hr_idx | input | IDX_W | Entry index read back by the host |
| hr_own | output | 1 | Ownership bit of entry hr_idx |
| hr_sop | output | 1 | Start marker of entry hr_idx |
| hr_eop | output | 1 | End marker of entry hr_idx |
| hr_add_fcs | output | 1 | Add-request bit of entry hr_idx |
| hr_lti | output | 1 | Notify flag of entry hr_idx |
| req_valid | output | 1 | Buffer request outstanding |
| req_addr | output | ADDR_W | Buffer address |
| req_cnt | output | CNT_W | Buffer byte count |
| req_first | output | 1 | Buffer opens a frame |
| req_last | output | 1 | Buffer closes a frame |
| req_fcs | output | 1 | Append checksum for this frame |
| req_done | input | 1 | Data mover finished the buffer |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt |
| tx_irq | output | 1 | Sticky transmit interrupt |
| err_uflow | output | 1 | One-cycle underflow pulse |

## Verification
The interrupt flag has two writers. A done pulse on an end-marked entry can raise it in the same cycle that the host's clear pulse tries to drop it. The bench drives the clear pulse together with the done pulse, both in a directed case and at random points in the random frames, and expects the flag to read 1 afterwards. A clear on its own must then bring the flag to 0. A second overlap is tested with writes: the bench writes each frame's entries last-to-first while the walker is already polling, so the host write port and the walker's poll act on the same entry. The bench expects no underflow pulse from this.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef struct packed {
    logic own;
    logic sop;
    logic eop;
    logic add_fcs;
    logic lti;
  } txd_flags_t;

  typedef enum logic [0:0] {
    ST_FETCH = 1'b0,
    ST_BUSY  = 1'b1
  } walk_st_e;

  function automatic logic fcs_pick(input logic autopad, input logic fcs_off,
                                    input logic add_req);
    if (autopad) return ~fcs_off;
    return add_req | ~fcs_off;
  endfunction

  function automatic logic irq_due(input logic eop, input logic lti,
                                   input logic lti_en);
    return eop & (~lti_en | lti);
  endfunction

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem
  import txr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  txd_flags_t        wr_flags,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output txd_flags_t        rd_flags,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [IDX_W-1:0]  hr_idx,
  output txd_flags_t        hr_flags
);

  txd_flags_t        flags_q [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_q   [DEPTH];

  logic wr_hit_clr;
  assign wr_hit_clr = wr_en && (wr_idx == clr_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) flags_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wr_en && wr_idx == IDX_W'(k))
          flags_q[k] <= wr_flags;
        else if (clr_en && clr_idx == IDX_W'(k))
          flags_q[k].own <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_idx] <= wr_addr;
      cnt_q[wr_idx]  <= wr_cnt;
    end
  end

  assign rd_flags = flags_q[rd_idx];
  assign rd_addr  = addr_q[rd_idx];
  assign rd_cnt   = cnt_q[rd_idx];
  assign hr_flags = flags_q[hr_idx];

  AST_OWN_GIVEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_hit_clr) |=> !flags_q[$past(clr_idx)].own); // R5

  AST_MARKERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_hit_clr) |=>
      (flags_q[$past(clr_idx)][3:0] == $past(flags_q[clr_idx][3:0]))); // R11

endmodule

// File: rtl/txr_irq_ctl.sv
module txr_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o); // R9

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o); // R9

endmodule

// File: rtl/txr_walk_ctl.sv
module txr_walk_ctl
  import txr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              autopad,
  input  logic              fcs_off,
  input  logic              lti_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  txd_flags_t        d_flags,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [CNT_W-1:0]  d_cnt,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_cnt,
  output logic              req_first,
  output logic              req_last,
  output logic              req_fcs,
  input  logic              req_done,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              irq_set,
  output logic              uflow
);

  walk_st_e         state;
  logic [IDX_W-1:0] cur_idx;
  logic             in_frame;
  logic             cur_lti;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    if (i == IDX_W'(DEPTH - 1)) return '0;
    return i + 1'b1;
  endfunction

  logic can_go, take, skip, starve, finish;
  assign can_go = (state == ST_FETCH) && run;
  assign take   = can_go && d_flags.own && (in_frame || d_flags.sop);
  assign skip   = can_go && d_flags.own && !in_frame && !d_flags.sop;
  assign starve = can_go && !d_flags.own && in_frame;
  assign finish = (state == ST_BUSY) && req_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      cur_idx   <= '0;
      in_frame  <= 1'b0;
      cur_lti   <= 1'b0;
      req_addr  <= '0;
      req_cnt   <= '0;
      req_first <= 1'b0;
      req_last  <= 1'b0;
      req_fcs   <= 1'b0;
      uflow     <= 1'b0;
    end else begin
      uflow <= starve;
      if (take) begin
        state     <= ST_BUSY;
        req_addr  <= d_addr;
        req_cnt   <= d_cnt;
        req_first <= !in_frame;
        req_last  <= d_flags.eop;
        cur_lti   <= d_flags.lti;
        if (!in_frame) req_fcs <= fcs_pick(autopad, fcs_off, d_flags.add_fcs);
      end
      if (skip)   cur_idx  <= step(cur_idx);
      if (starve) in_frame <= 1'b0;
      if (finish) begin
        state    <= ST_FETCH;
        cur_idx  <= step(cur_idx);
        in_frame <= !req_last;
      end
    end
  end

  assign rd_idx    = cur_idx;
  assign req_valid = (state == ST_BUSY);
  assign clr_en    = finish;
  assign clr_idx   = cur_idx;
  assign irq_set   = finish && irq_due(req_last, cur_lti, lti_en);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_done) |=>
      (req_valid && $stable(req_addr) && $stable(req_cnt) && $stable(req_last))); // R4

  AST_FCS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_first) |-> $stable(req_fcs)); // R6

  AST_UFLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> !req_valid); // R10

  AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !req_valid) |=> !req_valid); // R12

endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txr_pkg::*;
#(
  parameter int RING_DEPTH = 16,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = $clog2(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_run,
  input  logic              cfg_autopad,
  input  logic              cfg_fcs_off,
  input  logic              cfg_lti_en,
  input  logic              hw_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic              hw_own,
  input  logic              hw_sop,
  input  logic              hw_eop,
  input  logic              hw_add_fcs,
  input  logic              hw_lti,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [CNT_W-1:0]  hw_cnt,
  input  logic [IDX_W-1:0]  hr_idx,
  output logic              hr_own,
  output logic              hr_sop,
  output logic              hr_eop,
  output logic              hr_add_fcs,
  output logic              hr_lti,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_cnt,
  output logic              req_first,
  output logic              req_last,
  output logic              req_fcs,
  input  logic              req_done,
  input  logic              irq_clr,
  output logic              tx_irq,
  output logic              err_uflow
);

  txd_flags_t        wr_flags, rd_flags, hr_flags;
  logic [IDX_W-1:0]  rd_idx, clr_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  rd_cnt;
  logic              clr_en, irq_set;

  assign wr_flags = '{own: hw_own, sop: hw_sop, eop: hw_eop,
                      add_fcs: hw_add_fcs, lti: hw_lti};

  txr_desc_mem #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W))
  u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(hw_en), .wr_idx(hw_idx), .wr_flags(wr_flags),
    .wr_addr(hw_addr), .wr_cnt(hw_cnt),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .rd_idx(rd_idx), .rd_flags(rd_flags), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
    .hr_idx(hr_idx), .hr_flags(hr_flags)
  );

  txr_walk_ctl #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W))
  u_walk (
    .clk(clk), .rst_n(rst_n),
    .run(cfg_run), .autopad(cfg_autopad), .fcs_off(cfg_fcs_off), .lti_en(cfg_lti_en),
    .rd_idx(rd_idx), .d_flags(rd_flags), .d_addr(rd_addr), .d_cnt(rd_cnt),
    .req_valid(req_valid), .req_addr(req_addr), .req_cnt(req_cnt),
    .req_first(req_first), .req_last(req_last), .req_fcs(req_fcs),
    .req_done(req_done),
    .clr_en(clr_en), .clr_idx(clr_idx), .irq_set(irq_set), .uflow(err_uflow)
  );

  txr_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .irq_o(tx_irq)
  );

  assign hr_own     = hr_flags.own;
  assign hr_sop     = hr_flags.sop;
  assign hr_eop     = hr_flags.eop;
  assign hr_add_fcs = hr_flags.add_fcs;
  assign hr_lti     = hr_flags.lti;

  AST_IRQ_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(req_done && req_valid && req_last)); // R7

endmodule

// File: tb/txring_walker_test.sv
module txring_walker_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_run = 1'b0, cfg_autopad = 1'b0, cfg_fcs_off = 1'b0, cfg_lti_en = 1'b0;
  logic        hw_en = 1'b0, hw_own = 1'b0, hw_sop = 1'b0, hw_eop = 1'b0;
  logic        hw_add_fcs = 1'b0, hw_lti = 1'b0;
  logic [3:0]  hw_idx = '0, hr_idx = '0;
  logic [31:0] hw_addr = '0;
  logic [15:0] hw_cnt = '0;
  logic        hr_own, hr_sop, hr_eop, hr_add_fcs, hr_lti;
  logic        req_valid, req_first, req_last, req_fcs;
  logic [31:0] req_addr;
  logic [15:0] req_cnt;
  logic        req_done = 1'b0, irq_clr = 1'b0;
  logic        tx_irq, err_uflow;

  int checks = 0;
  int errors = 0;
  logic exp_irq = 1'b0;

  always #2.5 clk = ~clk;

  txring_walker uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_run(cfg_run), .cfg_autopad(cfg_autopad), .cfg_fcs_off(cfg_fcs_off),
    .cfg_lti_en(cfg_lti_en),
    .hw_en(hw_en), .hw_idx(hw_idx), .hw_own(hw_own), .hw_sop(hw_sop), .hw_eop(hw_eop),
    .hw_add_fcs(hw_add_fcs), .hw_lti(hw_lti), .hw_addr(hw_addr), .hw_cnt(hw_cnt),
    .hr_idx(hr_idx), .hr_own(hr_own), .hr_sop(hr_sop), .hr_eop(hr_eop),
    .hr_add_fcs(hr_add_fcs), .hr_lti(hr_lti),
    .req_valid(req_valid), .req_addr(req_addr), .req_cnt(req_cnt),
    .req_first(req_first), .req_last(req_last), .req_fcs(req_fcs),
    .req_done(req_done), .irq_clr(irq_clr), .tx_irq(tx_irq), .err_uflow(err_uflow)
  );

  function automatic logic want_fcs(input logic ap, input logic off, input logic add);
    case ({ap, add})
      2'b10, 2'b11: return !off;
      2'b01:        return 1'b1;
      default:      return !off;
    endcase
  endfunction

  function automatic logic want_irq(input logic eop, input logic lti, input logic en);
    if (!eop) return 1'b0;
    if (!en)  return 1'b1;
    return lti;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_desc(input int idx, input logic own, input logic sop, input logic eop,
                         input logic addf, input logic lti, input logic [31:0] a,
                         input logic [15:0] c);
    hw_en = 1'b1; hw_idx = 4'(idx); hw_own = own; hw_sop = sop; hw_eop = eop;
    hw_add_fcs = addf; hw_lti = lti; hw_addr = a; hw_cnt = c;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic serve(input int idx, input logic [31:0] a, input logic [15:0] c,
                       input logic first, input logic last, input logic fcs,
                       input logic irq_now, input logic clr_too);
    int n = 0;
    while (!req_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk("R2 request appears for owned entry", 64'(req_valid), 64'd1);
    chk("R4 address", 64'(req_addr), 64'(a));
    chk("R4 count", 64'(req_cnt), 64'(c));
    chk("R4 first flag", 64'(req_first), 64'(first));
    chk("R4 last flag", 64'(req_last), 64'(last));
    chk("R6 checksum decision", 64'(req_fcs), 64'(fcs));
    req_done = 1'b1; irq_clr = clr_too;
    @(negedge clk);
    req_done = 1'b0; irq_clr = 1'b0;
    if (irq_now) exp_irq = 1'b1;
    else if (clr_too) exp_irq = 1'b0;
    hr_idx = 4'(idx);
    #1;
    chk("R5 ownership returned", 64'(hr_own), 64'd0);
    chk("R11 start marker kept", 64'(hr_sop), 64'(first));
    chk("R11 end marker kept", 64'(hr_eop), 64'(last));
    chk("R7 R8 R9 interrupt", 64'(tx_irq), 64'(exp_irq));
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    exp_irq = 1'b0;
    chk("R9 clear drops interrupt", 64'(tx_irq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int widx;
    int seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 no request", 64'(req_valid), 64'd0);
    chk("R1 interrupt low", 64'(tx_irq), 64'd0);
    chk("R1 underflow low", 64'(err_uflow), 64'd0);
    hr_idx = 4'd0; #1;
    chk("R1 entry host-owned", 64'(hr_own), 64'd0);

    // R2: host-owned ring, nothing issued
    cfg_run = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (req_valid || err_uflow) seen = 1;
    end
    chk("R2 idle on host-owned entries", 64'(seen), 64'd0);

    // R3: entry 0 owned without start marker is stepped over
    wr_desc(1, 1, 1, 1, 0, 0, 32'hA000_0100, 16'd64);
    wr_desc(0, 1, 0, 1, 1, 0, 32'hA000_0000, 16'd32);
    serve(1, 32'hA000_0100, 16'd64, 1, 1, 1'b1, 1'b1, 1'b0); // R8 irq with lti=0
    hr_idx = 4'd0; #1;
    chk("R3 skipped entry stays owned", 64'(hr_own), 64'd1);
    chk("R3 skipped entry marker unchanged", 64'(hr_sop), 64'd0);
    clear_irq();

    // R10: underflow in the middle of a frame
    wr_desc(2, 1, 1, 0, 0, 0, 32'hB000_0200, 16'd100);
    serve(2, 32'hB000_0200, 16'd100, 1, 0, 1'b1, 1'b0, 1'b0);
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      if (err_uflow) seen++;
      @(negedge clk);
    end
    chk("R10 single underflow pulse", 64'(seen), 64'd1);
    wr_desc(3, 1, 0, 1, 0, 0, 32'hB000_0300, 16'd7);
    wr_desc(4, 1, 1, 1, 0, 0, 32'hB000_0400, 16'd8);
    serve(4, 32'hB000_0400, 16'd8, 1, 1, 1'b1, 1'b1, 1'b0); // R10 next frame restarts at SOP
    hr_idx = 4'd3; #1;
    chk("R10 non-start entry after underflow skipped", 64'(hr_own), 64'd1);
    wr_desc(0, 0, 0, 0, 0, 0, 32'h0, 16'h0);
    wr_desc(3, 0, 0, 0, 0, 0, 32'h0, 16'h0);
    clear_irq();

    // R12: run low holds the walker; R6 auto-pad overrides add; R7 lti=0 no irq
    cfg_run = 1'b0; cfg_autopad = 1'b1; cfg_fcs_off = 1'b1; cfg_lti_en = 1'b1;
    wr_desc(5, 1, 1, 1, 1, 0, 32'hC000_0500, 16'd60);
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    chk("R12 no request while halted", 64'(seen), 64'd0);
    cfg_run = 1'b1;
    serve(5, 32'hC000_0500, 16'd60, 1, 1, 1'b0, 1'b0, 1'b0);

    // R7: lti and eop both set raises irq
    wr_desc(6, 1, 1, 1, 0, 1, 32'hC000_0600, 16'd61);
    serve(6, 32'hC000_0600, 16'd61, 1, 1, 1'b0, 1'b1, 1'b0);
    clear_irq();

    // R6 latch: cfg changes mid-frame; R7 lti on non-last entry does not count
    cfg_autopad = 1'b0; cfg_fcs_off = 1'b1;
    wr_desc(8, 1, 0, 1, 0, 0, 32'hC000_0800, 16'd3);
    wr_desc(7, 1, 1, 0, 1, 1, 32'hC000_0700, 16'd2);
    serve(7, 32'hC000_0700, 16'd2, 1, 0, 1'b1, 1'b0, 1'b0);
    cfg_autopad = 1'b1;
    serve(8, 32'hC000_0800, 16'd3, 0, 1, 1'b1, 1'b0, 1'b0);

    // R9: raise and clear in the same cycle
    cfg_lti_en = 1'b0; cfg_autopad = 1'b0; cfg_fcs_off = 1'b0;
    wr_desc(9, 1, 1, 1, 0, 0, 32'hD000_0900, 16'd9);
    serve(9, 32'hD000_0900, 16'd9, 1, 1, 1'b1, 1'b1, 1'b0);
    wr_desc(10, 1, 1, 1, 0, 0, 32'hD000_0A00, 16'd10);
    serve(10, 32'hD000_0A00, 16'd10, 1, 1, 1'b1, 1'b1, 1'b1);
    chk("R9 set wins over clear", 64'(tx_irq), 64'd1);
    clear_irq();

    // Random frames; ring wraps several times (R5)
    widx = 11;
    for (int f = 0; f < 40; f++) begin
      int len;
      logic ef;
      logic [31:0] ad[3];
      logic [15:0] cn[3];
      logic        af[3], lt[3];
      len = 1 + int'($urandom % 3);
      cfg_autopad = 1'($urandom); cfg_fcs_off = 1'($urandom); cfg_lti_en = 1'($urandom);
      for (int b = 0; b < 3; b++) begin
        ad[b] = $urandom; cn[b] = 16'($urandom); af[b] = 1'($urandom); lt[b] = 1'($urandom);
      end
      for (int b = len - 1; b >= 0; b--)
        wr_desc((widx + b) % DEPTH, 1, b == 0, b == len - 1, af[b], lt[b], ad[b], cn[b]);
      ef = want_fcs(cfg_autopad, cfg_fcs_off, af[0]);
      for (int b = 0; b < len; b++) begin
        if (b > 0 && ($urandom % 2) == 1) begin
          cfg_autopad = 1'($urandom); cfg_fcs_off = 1'($urandom); cfg_lti_en = 1'($urandom);
        end
        serve((widx + b) % DEPTH, ad[b], cn[b], b == 0, b == len - 1, ef,
              want_irq(b == len - 1, lt[b], cfg_lti_en), 1'($urandom % 4 == 0));
      end
      widx = (widx + len) % DEPTH;
      if ($urandom % 3 == 0) clear_irq();
    end
    chk("R10 no underflow in random traffic", 64'(err_uflow), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule